// File: doc/BRIEF.md
# Parallel NOR Word-Program Sequencer

This block sits on the host side of a parallel NOR flash and turns a single start request into the complete command exchange needed to write one word. The controller emits the unlock and command writes over a plain synchronous bus master port. It then reads back the target word repeatedly until bit 7 shows the completion polarity. A final full-word read confirms the stored value, and the controller reports either success or a failure kind. The same machinery can run a whole-device erase instead, which writes a longer command string and polls for the erased polarity.

The bus port issues one strobe per cycle. A write is a single cycle with the write strobe high. A read is a single strobe cycle, and the memory presents its data in the following cycle, which the controller samples at the end of that cycle. Sticking programs are caught by the final read, where a stored 0 could not be raised to 1. Runaway operations are bounded by a parameterised poll limit and by the bit 5 fault flag. A runaway operation ends with a reset command (F0h) to the flash.

Top module: `nor_prog_ctrl`

## Requirements
- R1: When `start` is seen high in idle with `op_erase` low, the next four cycles each carry one write: 555h/AAh, 2AAh/55h, 555h/A0h, then the target address with the target word.
- R2: When `start` is seen high in idle with `op_erase` high, the next six cycles each carry one write: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h. The expected word for polling and checking is then all ones.
- R3: In the cycle right after the last command write, polling begins. Every read is one cycle with `bus_re` high at the target address, followed by one sampling cycle with no strobe. The next strobe, if any, follows that sampling cycle directly.
- R4: A poll read whose bit 7 equals bit 7 of the expected word ends polling. One further read of the target address is then made to check the whole word.
- R5: If the checking read equals the expected word, `done` pulses for one cycle. Otherwise `error` pulses for one cycle with `err_kind`=1. `done` and `error` are never high together.
- R6: A poll read with bit 7 wrong and bit 5 set causes exactly one repeat read. If the repeat also has bit 7 wrong, one write of F0h to the target address follows, then an `error` pulse with `err_kind`=0.
- R7: Poll reads with bit 7 wrong and bit 5 clear are counted. Repeat reads are not counted. When the POLL_LIMIT-th poll read is still wrong, the F0h write and an `err_kind`=0 error follow. A bit 7 match on that same read still succeeds.
- R8: `start` is ignored while an operation runs. The bus sequence is unchanged, and `op_erase`, `prog_addr` and `prog_data` matter only in the accepting cycle.
- R9: During and after reset, with no operation running, all strobes, `busy`, `done` and `error` are low. `busy` is high from the first write cycle until the cycle in which `done` or `error` pulses, where it is low. `bus_we` and `bus_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an operation (accepted only in idle) |
| op_erase | input | 1 | 1 = whole-device erase, 0 = word program |
| prog_addr | input | AW | Target word address (also the poll address for erase) |
| prog_data | input | DW | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle failure pulse |
| err_kind | output | 1 | With `error`: 0 = timeout/fault, 1 = word check mismatch |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_we | output | 1 | Write strobe, one cycle per write |
| bus_re | output | 1 | Read strobe, one cycle per read |
| bus_rdata | input | DW | Read data, valid in the cycle after `bus_re` |

## Verification
The hardest paths to reach are the fault exits. One is a bit 5 report followed by a second wrong read. The other is the poll read that lands exactly on the limit, where a match must still win over expiry. The bench's flash model is scripted per operation with a count of status reads that show the wrong bit 7, with or without bit 5. The count is set to one below, at, and well above the limit, and to one or two reads with bit 5, so each exit is steered deliberately. A sticking-bit case, where the stored value is the AND of old and new data, drives the word-check failure.

// File: rtl/nor_prog_pkg.sv
package nor_prog_pkg;
  localparam logic [11:0] UNLK_ADDR_A = 12'h555;
  localparam logic [11:0] UNLK_ADDR_B = 12'h2AA;
  localparam logic [7:0]  UNLK_DATA_A = 8'hAA;
  localparam logic [7:0]  UNLK_DATA_B = 8'h55;
  localparam logic [7:0]  OP_PROGRAM  = 8'hA0;
  localparam logic [7:0]  OP_ERASE_SU = 8'h80;
  localparam logic [7:0]  OP_ERASE_GO = 8'h10;
  localparam logic [7:0]  OP_RESET    = 8'hF0;
  localparam int unsigned PROG_STEPS  = 4;
  localparam int unsigned ERASE_STEPS = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE, ST_READ, ST_SAMPLE, ST_ABORT
  } ctrl_state_t;

  typedef enum logic [1:0] {
    RK_POLL, RK_RETRY, RK_CHECK
  } read_kind_t;
endpackage

// File: rtl/nor_cmd_table.sv
module nor_cmd_table
  import nor_prog_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          erase,
  input  logic [2:0]    step,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] tgt_data,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic [2:0]    n_steps
);
  localparam int AP = AW - 12;
  localparam int DP = DW - 8;

  logic [AW-1:0] a_lo, a_hi;
  logic [7:0]    op_byte;
  logic          is_target;

  assign a_lo = {{AP{1'b0}}, UNLK_ADDR_A};
  assign a_hi = {{AP{1'b0}}, UNLK_ADDR_B};
  assign n_steps = erase ? 3'(ERASE_STEPS) : 3'(PROG_STEPS);

  always_comb begin
    cmd_addr  = a_lo;
    op_byte   = UNLK_DATA_A;
    is_target = 1'b0;
    case (step)
      3'd0: begin cmd_addr = a_lo; op_byte = UNLK_DATA_A; end
      3'd1: begin cmd_addr = a_hi; op_byte = UNLK_DATA_B; end
      3'd2: begin cmd_addr = a_lo; op_byte = erase ? OP_ERASE_SU : OP_PROGRAM; end
      3'd3: begin
        if (erase) begin
          cmd_addr = a_lo; op_byte = UNLK_DATA_A;
        end else begin
          cmd_addr = tgt_addr; is_target = 1'b1;
        end
      end
      3'd4: begin cmd_addr = a_hi; op_byte = UNLK_DATA_B; end
      default: begin cmd_addr = a_lo; op_byte = OP_ERASE_GO; end
    endcase
    cmd_data = is_target ? tgt_data : {{DP{1'b0}}, op_byte};
  end
endmodule

// File: rtl/nor_status_eval.sv
module nor_status_eval #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] expect_word,
  output logic          polarity_ok,
  output logic          fault_flag,
  output logic          word_ok
);
  assign polarity_ok = (rdata[7] == expect_word[7]);
  assign fault_flag  = rdata[5];
  assign word_ok     = (rdata == expect_word);
endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
  parameter int POLL_LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic expired
);
  localparam int CW = $clog2(POLL_LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == CW'(POLL_LIMIT - 1));

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(POLL_LIMIT));
  p_no_inc_at_limit_r7: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |-> !expired);
endmodule

// File: rtl/nor_prog_ctrl.sv
module nor_prog_ctrl
  import nor_prog_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int POLL_LIMIT = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op_erase,
  input  logic [AW-1:0] prog_addr,
  input  logic [DW-1:0] prog_data,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic          err_kind,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_we,
  output logic          bus_re,
  input  logic [DW-1:0] bus_rdata
);
  localparam int DP = DW - 8;

  ctrl_state_t   state;
  read_kind_t    rkind;
  logic [2:0]    step;
  logic          is_erase;
  logic [AW-1:0] tgt_addr;
  logic [DW-1:0] tgt_data;

  logic          accept;
  logic          sel_erase;
  logic [2:0]    sel_step;
  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_data;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic [2:0]    n_steps;
  logic          pol_ok, fault, word_ok, expired;
  logic          tmr_inc;

  assign accept    = (state == ST_IDLE) && start;
  assign sel_erase = (state == ST_IDLE) ? op_erase : is_erase;
  assign sel_step  = (state == ST_IDLE) ? 3'd0 : step;
  assign sel_addr  = (state == ST_IDLE) ? prog_addr : tgt_addr;
  assign sel_data  = (state == ST_IDLE) ? (op_erase ? {DW{1'b1}} : prog_data) : tgt_data;

  nor_cmd_table #(.AW(AW), .DW(DW)) u_table (
    .erase(sel_erase), .step(sel_step), .tgt_addr(sel_addr), .tgt_data(sel_data),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .n_steps(n_steps)
  );

  nor_status_eval #(.DW(DW)) u_eval (
    .rdata(bus_rdata), .expect_word(tgt_data),
    .polarity_ok(pol_ok), .fault_flag(fault), .word_ok(word_ok)
  );

  assign tmr_inc = (state == ST_SAMPLE) && (rkind == RK_POLL)
                   && !pol_ok && !fault && !expired;

  nor_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst(rst), .clr(accept), .inc(tmr_inc), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rkind     <= RK_POLL;
      step      <= '0;
      is_erase  <= 1'b0;
      tgt_addr  <= '0;
      tgt_data  <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      err_kind  <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            is_erase  <= op_erase;
            tgt_addr  <= prog_addr;
            tgt_data  <= sel_data;
            bus_addr  <= cmd_addr;
            bus_wdata <= cmd_data;
            bus_we    <= 1'b1;
            busy      <= 1'b1;
            step      <= 3'd1;
            state     <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (step == n_steps) begin
            bus_we   <= 1'b0;
            bus_re   <= 1'b1;
            bus_addr <= tgt_addr;
            rkind    <= RK_POLL;
            state    <= ST_READ;
          end else begin
            bus_addr  <= cmd_addr;
            bus_wdata <= cmd_data;
            step      <= step + 3'd1;
          end
        end
        ST_READ: begin
          bus_re <= 1'b0;
          state  <= ST_SAMPLE;
        end
        ST_SAMPLE: begin
          case (rkind)
            RK_CHECK: begin
              busy     <= 1'b0;
              state    <= ST_IDLE;
              done     <= word_ok;
              error    <= !word_ok;
              err_kind <= 1'b1;
            end
            default: begin
              if (pol_ok) begin
                rkind  <= RK_CHECK;
                bus_re <= 1'b1;
                state  <= ST_READ;
              end else if (rkind == RK_POLL && fault) begin
                rkind  <= RK_RETRY;
                bus_re <= 1'b1;
                state  <= ST_READ;
              end else if (rkind == RK_RETRY || expired) begin
                bus_we    <= 1'b1;
                bus_wdata <= {{DP{1'b0}}, OP_RESET};
                state     <= ST_ABORT;
              end else begin
                bus_re <= 1'b1;
                state  <= ST_READ;
              end
            end
          endcase
        end
        ST_ABORT: begin
          bus_we   <= 1'b0;
          busy     <= 1'b0;
          error    <= 1'b1;
          err_kind <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re));
  p_strobe_needs_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_we || bus_re) |-> busy);
  p_pulse_drops_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (done || error) |-> !busy);
  p_done_error_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(done && error));
  p_read_single_r3: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> !bus_re);
  p_first_unlock_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start) |=>
      (bus_we && bus_addr[11:0] == UNLK_ADDR_A && bus_wdata[7:0] == UNLK_DATA_A));
  p_reset_cmd_before_fault_r6: assert property (@(posedge clk) disable iff (rst)
    (error && !err_kind) |-> $past(bus_we && bus_wdata[7:0] == OP_RESET));
  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !done && !error) |=> $stable(tgt_addr));
endmodule

// File: tb/nor_prog_ctrl_bench.sv
`timescale 1ns/1ps
module nor_prog_ctrl_bench;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int LIM = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          op_erase = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic [DW-1:0] prog_data = '0;
  logic          busy, done, error, err_kind, bus_we, bus_re;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;

  nor_prog_ctrl #(.AW(AW), .DW(DW), .POLL_LIMIT(LIM)) u_nor_prog_ctrl (
    .clk(clk), .rst(rst), .start(start), .op_erase(op_erase),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .busy(busy), .done(done), .error(error), .err_kind(err_kind),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_re(bus_re), .bus_rdata(bus_rdata)
  );

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic we, re, bsy, dn, er, kind;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
  } cyc_t;

  cyc_t  exp_q[$];
  string tag_q[$];
  int vectors = 0;
  int miscompares = 0;

  // scripted flash: status reads with wrong bit 7, then the final word
  int            m_busy_left = 0;
  bit            m_fault = 1'b0;
  bit            m_pol = 1'b0;
  bit            m_tog = 1'b0;
  logic [DW-1:0] m_final = '0;

  always @(posedge clk) begin
    if (bus_re) begin
      if (m_busy_left > 0) begin
        logic [DW-1:0] w;
        w = '0;
        w[7] = ~m_pol;
        w[6] = m_tog;
        w[5] = m_fault;
        m_tog = ~m_tog;
        m_busy_left = m_busy_left - 1;
        bus_rdata <= w;
      end else begin
        bus_rdata <= m_final;
      end
    end
  end

  function automatic cyc_t mk(logic we, logic re, logic b, logic d, logic e,
                              logic k, logic [AW-1:0] a, logic [DW-1:0] wd);
    cyc_t c;
    c.we = we; c.re = re; c.bsy = b; c.dn = d; c.er = e; c.kind = k;
    c.addr = a; c.wdata = wd;
    return c;
  endfunction

  task automatic push(cyc_t c, string t);
    exp_q.push_back(c);
    tag_q.push_back(t);
  endtask

  task automatic push_wr(logic [AW-1:0] a, logic [DW-1:0] d, string t);
    push(mk(1, 0, 1, 0, 0, 0, a, d), t);
  endtask

  task automatic push_rd(logic [AW-1:0] a, string t);
    push(mk(0, 1, 1, 0, 0, 0, a, '0), t);
    push(mk(0, 0, 1, 0, 0, 0, '0, '0), t);
  endtask

  task automatic tick;
    cyc_t e;
    string t;
    bit bad;
    @(negedge clk);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
    end else begin
      e = mk(0, 0, 0, 0, 0, 0, '0, '0);
      t = "R9";
    end
    vectors++;
    bad = (bus_we !== e.we) || (bus_re !== e.re) || (busy !== e.bsy)
       || (done !== e.dn) || (error !== e.er)
       || ((e.we || e.re) && bus_addr !== e.addr)
       || (e.we && bus_wdata !== e.wdata)
       || (e.er && err_kind !== e.kind);
    if (bad) begin
      miscompares++;
      $display("FAIL %s t=%0t act we=%b re=%b busy=%b done=%b err=%b kind=%b a=%h d=%h exp we=%b re=%b busy=%b done=%b err=%b kind=%b a=%h d=%h",
        t, $time, bus_we, bus_re, busy, done, error, err_kind, bus_addr, bus_wdata,
        e.we, e.re, e.bsy, e.dn, e.er, e.kind, e.addr, e.wdata);
    end
  endtask

  // builds the expected cycles from the requirements and the flash script
  task automatic expect_op(bit er, logic [AW-1:0] a, logic [DW-1:0] d,
                           int nb, bit flt, logic [DW-1:0] fin);
    logic [DW-1:0] want;
    int left, polls;
    bit finished;
    want = er ? '1 : d;
    if (er) begin
      push_wr(20'h00555, 16'h00AA, "R2");
      push_wr(20'h002AA, 16'h0055, "R2");
      push_wr(20'h00555, 16'h0080, "R2");
      push_wr(20'h00555, 16'h00AA, "R2");
      push_wr(20'h002AA, 16'h0055, "R2");
      push_wr(20'h00555, 16'h0010, "R2");
    end else begin
      push_wr(20'h00555, 16'h00AA, "R1");
      push_wr(20'h002AA, 16'h0055, "R1");
      push_wr(20'h00555, 16'h00A0, "R1");
      push_wr(a, d, "R1");
    end
    left = nb; polls = 0; finished = 0;
    while (!finished) begin
      push_rd(a, "R3");
      if (left > 0) begin
        left--;
        if (flt) begin
          push_rd(a, "R6");
          if (left > 0) begin
            left--;
            push_wr(a, 16'h00F0, "R6");
            push(mk(0, 0, 0, 0, 1, 0, '0, '0), "R6");
            return;
          end
          finished = 1;
        end else begin
          polls++;
          if (polls == LIM) begin
            push_wr(a, 16'h00F0, "R7");
            push(mk(0, 0, 0, 0, 1, 0, '0, '0), "R7");
            return;
          end
        end
      end else begin
        finished = 1;
      end
    end
    push_rd(a, "R4");
    if (fin == want) push(mk(0, 0, 0, 1, 0, 0, '0, '0), "R5");
    else             push(mk(0, 0, 0, 0, 1, 1, '0, '0), "R5");
  endtask

  task automatic run(bit er, logic [AW-1:0] a, logic [DW-1:0] d, int nb,
                     bit flt, logic [DW-1:0] fin, int poke);
    int cyc;
    m_busy_left = nb; m_fault = flt; m_final = fin;
    m_pol = er ? 1'b1 : d[7];
    op_erase = er; prog_addr = a; prog_data = d; start = 1'b1;
    expect_op(er, a, d, nb, flt, fin);
    cyc = 0;
    while (exp_q.size() > 0) begin
      tick();
      cyc++;
      // R8: a second start while busy, with different operands
      if (cyc == poke) begin
        start = 1'b1; op_erase = ~er; prog_addr = ~a; prog_data = ~d;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    repeat (3) tick();
  endtask

  initial begin
    #(5ns * 20000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R9: outputs quiet in and after reset
    repeat (4) tick();
    rst = 1'b0;
    repeat (3) tick();
    run(0, 20'h00ABC, 16'h1234, 3, 0, 16'h1234, 0);  // R1 R3 R4 R5
    run(0, 20'hF0F0F, 16'h80FF, 0, 0, 16'h80FF, 0);  // immediate match
    run(1, 20'h12345, 16'h0000, 4, 0, 16'hFFFF, 0);  // R2 erase
    run(0, 20'h00010, 16'h0F0F, 2, 0, 16'h0000, 0);  // R5 sticking zeros
    run(0, 20'h00020, 16'h5A5A, 1, 1, 16'h5A5A, 0);  // R6 retry succeeds
    run(0, 20'h00030, 16'hA5A5, 2, 1, 16'hA5A5, 0);  // R6 fault abort
    run(0, 20'h00040, 16'h00C3, LIM - 1, 0, 16'h00C3, 0); // R7 match on last poll
    run(0, 20'h00050, 16'h00C3, LIM, 0, 16'h00C3, 0);     // R7 limit reached
    run(1, 20'h00060, 16'h0000, 50, 0, 16'hFFFF, 0);      // R7 long stall
    run(0, 20'h00070, 16'h7E81, 2, 0, 16'h7E81, 3);       // R8 start during writes
    run(0, 20'h00080, 16'h1111, 2, 0, 16'h1111, 8);       // R8 start during polls
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule